// File: doc/BRIEF.md
# Address-Encoded I/O Timing Sequencer

This block turns single I/O-space requests from a core into pin-level bus cycles: chip select, active-low read and write strobes, address and data output enables. The block does not read the timing of a cycle from a configuration register. Each access carries its own timing in the I/O address. One address field sets the number of setup cycles. A second field sets the length of the strobe. A third field, together with the direction of the access, sets the bus hold time. A separate address bit selects data-strobe mode. In that mode a write pulses the read strobe and the write strobe stays high.

The core holds `req_i` together with the address, the write flag and the write data until `ack_o` pulses for one cycle. On a read, `rdata_o` is valid in that ack cycle. An external wait line can stretch the strobe phase. The wait line shares its pin with an interrupt source, so its active level comes from `wait_pol_i`. After a wait-stretched access the hold phase gets longer, so that bus recovery time is kept.

Top module: `io_tseq`

## Requirements
- R1: During reset and right after it, `io_cs_no`, `io_rd_no` and `io_wr_no` are high, and `io_addr_oe_o`, `io_data_oe_o` and `ack_o` are low.
- R2: Address bits 11..9 hold the setup code. It gives 0..6 setup cycles, and code 7 counts as 6. Setup cycles begin in the cycle after the request is accepted. During setup the chip select is low, the address is driven and enabled, and both strobes are high.
- R3: Address bits 8..5 hold the access code. The strobe phase lasts code+2 cycles, and code 15 is clamped to 16. It follows setup directly.
- R4: Address bits 4..3 hold the hold code h. A read holds for 2h cycles and a write for 2h+1 cycles. During hold the chip select stays low, the address stays enabled and both strobes are high.
- R5: Address bit 2 selects data-strobe mode. A write in this mode drives `io_rd_no` low in place of `io_wr_no`. A write without it drives `io_wr_no`. A read always drives `io_rd_no`. The two strobes are never low together.
- R6: In the last strobe cycle, an active wait line (high when `wait_pol_i`=1, low when 0) adds one strobe cycle per active sample. A wait seen in earlier strobe cycles has no effect.
- R7: After an access stretched by wait, the hold phase lasts at least 3 cycles. The next strobe phase therefore starts at least 4 cycles after the wait ends.
- R8: `io_data_oe_o` is high only for writes, from the first strobe cycle through the last hold cycle, with `io_data_o` equal to the write data.
- R9: `ack_o` pulses for one cycle, in the cycle after the last setup, strobe or hold cycle. On a read, `rdata_o` then holds `io_data_i` as sampled in the final strobe cycle. A request still present in the ack cycle is not accepted until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack |
| req_addr_i | input | ADDR_W | I/O address including timing fields |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read data, valid with ack |
| wait_pol_i | input | 1 | Wait active level (1 = high) |
| io_wait_i | input | 1 | External wait line |
| io_data_i | input | DATA_W | Bus data in |
| io_addr_o | output | ADDR_W | Bus address |
| io_addr_oe_o | output | 1 | Address output enable |
| io_cs_no | output | 1 | Chip select, active low |
| io_rd_no | output | 1 | Read or data strobe, active low |
| io_wr_no | output | 1 | Write strobe, active low |
| io_data_o | output | DATA_W | Bus data out |
| io_data_oe_o | output | 1 | Data output enable |

## Verification
The patterns cover zero and non-zero setup, the shortest and the clamped longest field codes, and every hold code for both directions. Together they show whether each field is decoded at its own bit position with its own offset and clamp. Writes with and without the data-strobe bit show which strobe pin is chosen. Wait pulses of several lengths with both polarities are applied, and they also cover the earlier strobe cycles. These runs separate a real stretch of the last cycle from a reaction to any wait sample, and check that the hold is lengthened only after a stretch. The read data bus holds a wrong value in every cycle except the final strobe cycle, so a sample taken in the wrong cycle shows up. Back-to-back requests that stay high through the ack cycle show whether the block starts a second access too early.

// File: rtl/io_tseq_pkg.sv
package io_tseq_pkg;
  localparam int unsigned CNT_W         = 5;
  localparam int unsigned DSTB_BIT      = 2;
  localparam int unsigned HOLD_LSB      = 3;
  localparam int unsigned HOLD_W        = 2;
  localparam int unsigned ACC_LSB       = 5;
  localparam int unsigned ACC_W         = 4;
  localparam int unsigned SETUP_LSB     = 9;
  localparam int unsigned SETUP_W       = 3;
  localparam int unsigned FIELD_W       = SETUP_LSB + SETUP_W - HOLD_LSB;
  localparam int unsigned SETUP_MAX     = 6;
  localparam int unsigned ACC_MIN       = 2;
  localparam int unsigned ACC_MAX       = 16;
  localparam int unsigned WAIT_HOLD_MIN = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup_cyc;
    logic [CNT_W-1:0] acc_cyc;
    logic [CNT_W-1:0] hold_cyc;
  } timing_t;
endpackage

// File: rtl/io_tseq_decode.sv
module io_tseq_decode
  import io_tseq_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic               we_i,
  output timing_t            timing_o
);
  localparam int unsigned S_OFF = SETUP_LSB - HOLD_LSB;
  localparam int unsigned A_OFF = ACC_LSB - HOLD_LSB;

  logic [SETUP_W-1:0] s_code;
  logic [ACC_W-1:0]   a_code;
  logic [HOLD_W-1:0]  h_code;
  logic [CNT_W-1:0]   s_ext, a_sum;

  assign s_code = field_i[S_OFF +: SETUP_W];
  assign a_code = field_i[A_OFF +: ACC_W];
  assign h_code = field_i[0 +: HOLD_W];
  assign s_ext  = CNT_W'(s_code);
  assign a_sum  = CNT_W'(a_code) + CNT_W'(ACC_MIN);

  always_comb begin
    timing_o.setup_cyc = (s_ext > CNT_W'(SETUP_MAX)) ? CNT_W'(SETUP_MAX) : s_ext;
    timing_o.acc_cyc   = (a_sum > CNT_W'(ACC_MAX))   ? CNT_W'(ACC_MAX)   : a_sum;
    // reads hold 2h, writes 2h+1
    timing_o.hold_cyc  = CNT_W'({h_code, we_i});
  end
endmodule

// File: rtl/io_tseq_seq.sv
module io_tseq_seq
  import io_tseq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  timing_t timing_i,
  input  logic    wait_act_i,
  output phase_e  phase_o,
  output logic    capture_o,
  output logic    done_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] acc_q, hold_q, hold_eff;
  logic             waited_q, waited_d;
  logic             done_q, done_d;
  logic             last_acc;

  assign last_acc = (phase_q == PH_ACCESS) && (cnt_q == '0);
  assign hold_eff = (waited_q && (hold_q < CNT_W'(WAIT_HOLD_MIN))) ? CNT_W'(WAIT_HOLD_MIN) : hold_q;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    waited_d = waited_q;
    done_d   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          waited_d = 1'b0;
          if (timing_i.setup_cyc != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = timing_i.setup_cyc - CNT_W'(1);
          end else begin
            phase_d = PH_ACCESS;
            cnt_d   = timing_i.acc_cyc - CNT_W'(1);
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACCESS;
          cnt_d   = acc_q - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_ACCESS: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (wait_act_i) begin
          waited_d = 1'b1;
        end else if (hold_eff != '0) begin
          phase_d = PH_HOLD;
          cnt_d   = hold_eff - CNT_W'(1);
        end else begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      acc_q    <= '0;
      hold_q   <= '0;
      waited_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      waited_q <= waited_d;
      done_q   <= done_d;
      if (start_i && (phase_q == PH_IDLE)) begin
        acc_q  <= timing_i.acc_cyc;
        hold_q <= timing_i.hold_cyc;
      end
    end
  end

  assign phase_o   = phase_q;
  assign capture_o = last_acc && !wait_act_i;
  assign done_o    = done_q;
endmodule

// File: rtl/io_tseq_pins.sv
module io_tseq_pins
  import io_tseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 32
) (
  input  phase_e            phase_i,
  input  logic              we_i,
  input  logic              dstrobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic              io_addr_oe_o,
  output logic              io_cs_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic [DATA_W-1:0] io_data_o,
  output logic              io_data_oe_o
);
  logic active, in_acc, in_acc_or_hold;

  assign active         = (phase_i != PH_IDLE);
  assign in_acc         = (phase_i == PH_ACCESS);
  assign in_acc_or_hold = in_acc || (phase_i == PH_HOLD);

  assign io_addr_o    = addr_i;
  assign io_addr_oe_o = active;
  assign io_cs_no     = !active;
  // data-strobe mode moves the write pulse onto the read pin
  assign io_rd_no     = !(in_acc && (!we_i || dstrobe_i));
  assign io_wr_no     = !(in_acc && we_i && !dstrobe_i);
  assign io_data_o    = wdata_i;
  assign io_data_oe_o = we_i && in_acc_or_hold;
endmodule

// File: rtl/io_tseq.sv
module io_tseq
  import io_tseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wait_pol_i,
  input  logic              io_wait_i,
  input  logic [DATA_W-1:0] io_data_i,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic              io_addr_oe_o,
  output logic              io_cs_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic [DATA_W-1:0] io_data_o,
  output logic              io_data_oe_o
);
  timing_t           timing;
  phase_e            phase;
  logic              accept, capture, wait_act;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign wait_act = wait_pol_i ? io_wait_i : !io_wait_i;
  // ack cycle blocks a still-held request
  assign accept   = req_i && (phase == PH_IDLE) && !ack_o;

  io_tseq_decode u_decode (
    .field_i  (req_addr_i[HOLD_LSB +: FIELD_W]),
    .we_i     (req_we_i),
    .timing_o (timing)
  );

  io_tseq_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .timing_i   (timing),
    .wait_act_i (wait_act),
    .phase_o    (phase),
    .capture_o  (capture),
    .done_o     (ack_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (capture && !we_q) rdata_q <= io_data_i;
    end
  end

  assign rdata_o = rdata_q;

  io_tseq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .phase_i      (phase),
    .we_i         (we_q),
    .dstrobe_i    (addr_q[DSTB_BIT]),
    .addr_i       (addr_q),
    .wdata_i      (wdata_q),
    .io_addr_o    (io_addr_o),
    .io_addr_oe_o (io_addr_oe_o),
    .io_cs_no     (io_cs_no),
    .io_rd_no     (io_rd_no),
    .io_wr_no     (io_wr_no),
    .io_data_o    (io_data_o),
    .io_data_oe_o (io_data_oe_o)
  );
endmodule

// File: rtl/io_tseq_chk.sv
module io_tseq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ack_o,
  input logic wait_pol_i,
  input logic io_wait_i,
  input logic io_cs_no,
  input logic io_rd_no,
  input logic io_wr_no,
  input logic io_data_oe_o
);
  logic strobe_low, wait_act;
  assign strobe_low = !io_rd_no || !io_wr_no;
  assign wait_act   = wait_pol_i ? io_wait_i : !io_wait_i;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!io_rd_no && !io_wr_no)); // R5
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_low |-> !io_cs_no); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_low && wait_act) |=> strobe_low); // R6
  AST_DOE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_data_oe_o |-> !io_cs_no); // R8
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R9
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> io_cs_no); // R9
endmodule

bind io_tseq io_tseq_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_o        (ack_o),
  .wait_pol_i   (wait_pol_i),
  .io_wait_i    (io_wait_i),
  .io_cs_no     (io_cs_no),
  .io_rd_no     (io_rd_no),
  .io_wr_no     (io_wr_no),
  .io_data_oe_o (io_data_oe_o)
);

// File: tb/io_tseq_tb_top.sv
`timescale 1ns/1ps
module io_tseq_tb_top;
  localparam int AW = 26;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, req_we, wait_pol, io_wait;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, io_data_in;
  logic          ack;
  logic [DW-1:0] rdata, io_data_out;
  logic [AW-1:0] io_addr;
  logic          io_addr_oe, io_cs_n, io_rd_n, io_wr_n, io_data_oe;

  int nchk = 0;
  int nbad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  io_tseq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_wdata_i(req_wdata), .ack_o(ack), .rdata_o(rdata),
    .wait_pol_i(wait_pol), .io_wait_i(io_wait), .io_data_i(io_data_in),
    .io_addr_o(io_addr), .io_addr_oe_o(io_addr_oe), .io_cs_no(io_cs_n),
    .io_rd_no(io_rd_n), .io_wr_no(io_wr_n), .io_data_o(io_data_out),
    .io_data_oe_o(io_data_oe)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "cs_n", io_cs_n, 1);
    chk(tag, "rd_n", io_rd_n, 1);
    chk(tag, "wr_n", io_wr_n, 1);
    chk(tag, "addr_oe", io_addr_oe, 0);
    chk(tag, "data_oe", io_data_oe, 0);
    chk(tag, "ack", ack, 0);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_idle("R9");
    end
  endtask

  // reference: per-cycle phase schedule built from the field rules
  task automatic run(input int sc, input int ac, input int hc, input bit we,
                     input bit ds, input int w, input bit pol,
                     input logic [DW-1:0] wd, input logic [DW-1:0] rv,
                     input logic [13:0] hi);
    int s, a, h, hnom, n, ph;
    logic [AW-1:0] adr;
    string tg;
    bit exp_rd, exp_wr, exp_doe;
    s    = (sc > 6) ? 6 : sc;
    a    = (ac + 2 > 16) ? 16 : ac + 2;
    hnom = we ? 2 * hc + 1 : 2 * hc;
    h    = (w > 0 && hnom < 3) ? 3 : hnom;
    n    = s + a + w + h;
    adr  = {hi, 3'(sc), 4'(ac), 2'(hc), ds, 2'b01};
    @(negedge clk);
    chk("R9", "no start in ack cycle cs_n", io_cs_n, 1);
    chk("R9", "ack low before start", ack, 0);
    req = 1'b1; req_addr = adr; req_we = we; req_wdata = wd;
    wait_pol = pol; io_wait = !pol; io_data_in = ~rv;
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      if (k <= s) ph = 1;
      else if (k <= s + a + w) ph = 2;
      else if (k <= n) ph = 3;
      else ph = 0;
      if (ph == 1) tg = "R2";
      else if (ph == 2) tg = (k > s + a) ? "R6" : "R3";
      else if (ph == 3) tg = (k > s + a + w + hnom) ? "R7" : "R4";
      else tg = "R9";
      exp_rd  = !(ph == 2 && (!we || ds));
      exp_wr  = !(ph == 2 && we && !ds);
      exp_doe = we && (ph == 2 || ph == 3);
      chk(tg, "cs_n", io_cs_n, (ph == 0));
      chk(tg, "addr_oe", io_addr_oe, (ph != 0));
      if (ph != 0) chk("R2", "addr", io_addr, adr);
      chk((we && ds) ? "R5" : tg, "rd_n", io_rd_n, exp_rd);
      chk((we && ds) ? "R5" : tg, "wr_n", io_wr_n, exp_wr);
      chk("R8", "data_oe", io_data_oe, exp_doe);
      if (exp_doe) chk("R8", "data_out", io_data_out, wd);
      chk("R9", "ack", ack, (k == n + 1));
      if (k == n + 1 && !we) chk("R9", "rdata", rdata, rv);
      io_wait    = (k >= s + 1 && k <= s + a + w - 1) ? pol : !pol;
      io_data_in = (k == s + a + w) ? rv : ~rv;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    wait_pol = 1'b1; io_wait = 1'b0; io_data_in = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    idle(2);
    // shortest read, then field coverage
    run(0, 0, 0, 0, 0, 0, 1, 32'h0, 32'hA5A5_0001, 14'h001);
    run(3, 5, 2, 0, 0, 0, 1, 32'h0, 32'h1234_5678, 14'h2A5);
    run(1, 2, 1, 1, 0, 0, 1, 32'hCAFE_0001, 32'h0, 14'h3FF);
    run(2, 1, 0, 1, 1, 0, 1, 32'hBEEF_0002, 32'h0, 14'h100);
    run(7, 15, 3, 0, 0, 0, 0, 32'h0, 32'h0F0F_F0F0, 14'h055);   // clamps R2 R3
    run(0, 0, 3, 1, 0, 0, 1, 32'h8000_0001, 32'h0, 14'h000);
    idle(3);
    // wait stretching
    run(1, 3, 0, 0, 0, 3, 1, 32'h0, 32'h5555_AAAA, 14'h010);    // R6 R7
    run(0, 2, 3, 1, 0, 2, 0, 32'h1357_9BDF, 32'h0, 14'h020);    // long hold kept
    run(2, 0, 1, 0, 1, 1, 0, 32'h0, 32'h0BAD_F00D, 14'h030);    // ds on read
    run(0, 0, 0, 1, 1, 4, 1, 32'h7777_1111, 32'h0, 14'h040);
    idle(1);
    for (int i = 0; i < 12; i++) begin
      run(i % 8, (i * 5) % 16, i % 4, bit'(i % 2), bit'((i / 2) % 2),
          i % 3, bit'((i / 3) % 2), 32'h1000_0000 + i, 32'h2000_0000 + 7 * i,
          14'(i * 37));
    end
    idle(2);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule